// File: doc/BRIEF.md
# Strobe-Clocked Input Deserializer with Core-Side Read FIFO

This block takes a parallel data bus from an external device, together with the strobe that the device drives alongside it. It samples the bus on the strobe, on the rising edge only (single data rate) or on both edges (double data rate). Each write edge collects one slot of beats. A slot is the beats of one strobe period: one beat in single data rate, a rising beat and a falling beat in double data rate. Slots go into a small FIFO whose pointers cross into the core clock domain in Gray code. The core runs at full, half or quarter rate, which gives 1, 2 or 4 slots per core word.

The core does not receive a free-running stream. After it has issued a read command, it raises a read-enable vector with one bit per slot. Two core cycles later it receives a valid vector with one bit per slot and the widened data word. A slot requested while the FIFO is empty comes back not valid, and the FIFO is left untouched. Reads are honoured only while the interface-locked input and the strobe-stable input are both high. When either falls, or when the synchronous core reset is raised, the FIFO is flushed.

Top module: `strobe_rx_deser`

## Requirements
- R1: `rd_data` is SLOTS*PIN_WIDTH*B bits wide, where B is 2 in double data rate and 1 in single data rate. Slot i occupies bits [i*PIN_WIDTH*B +: PIN_WIDTH*B], and lower-numbered valid slots carry older FIFO entries.
- R2: In double data rate, each slot holds the beat sampled on a rising strobe edge in its low PIN_WIDTH bits and the beat sampled on the falling edge that follows in its high PIN_WIDTH bits. A slot is written on that falling edge.
- R3: In single data rate, each rising strobe edge writes one slot of PIN_WIDTH bits, namely the bus value at that edge.
- R4: A read-enable bit sampled at core edge k, when served, gives a valid bit and slot data at core edge k+2. Valid lasts one cycle for each request, and no valid bit appears at edge k+1.
- R5: A requested slot finds the FIFO empty: its valid bit is 0 and its slot data is 0. The read pointer does not move, so data that arrives later goes to the next read.
- R6: Within one cycle, the enabled slots are served in ascending slot order from consecutive FIFO entries until the entries run out. Disabled or unserved slots return valid 0 and data 0.
- R7: While `iface_locked` or `strobe_ok` is low, the FIFO is flushed and read enables are ignored. `rd_valid` is 0 from the next cycle on. Entries captured before the drop are lost.
- R8: `core_rst` sampled high flushes the FIFO and clears `rd_valid` and `rd_data` from the next cycle on.
- R9: The FIFO holds DEPTH slots. Slots arriving while it is full are dropped, and the oldest DEPTH slots are kept.
- R10: After a flush ends, the write side leaves reset on the strobe. The first two slot-writing strobe edges are discarded: falling edges in double data rate, rising edges in single data rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| strobe_clk | input | 1 | Strobe from the external device, used as the capture clock |
| data_in | input | PIN_WIDTH | Data bus, aligned to the strobe |
| core_clk | input | 1 | Core clock |
| core_rst | input | 1 | Synchronous reset, active high, core domain |
| iface_locked | input | 1 | Interface lock indication, core domain |
| strobe_ok | input | 1 | Strobe-stable indication, core domain |
| rd_en | input | SLOTS | Per-slot read request |
| rd_valid | output | SLOTS | Per-slot valid, two core cycles after the request |
| rd_data | output | SLOTS*PIN_WIDTH*B | Widened data word, slot 0 in the low bits |

## Verification
A read pointer that slips, or a write pointer that is wrongly synchronized, shows at the ports on the next read. The pattern-coded data then arrives shifted by whole slots, or duplicated, two cycles after the request. A flush that leaves stale pointers behind makes valid bits rise after a relock even though no new strobe beats arrived. A swapped beat order inside a slot shows as exchanged nibbles in the very first valid word. Wrong depth or full handling shows when a burst longer than the FIFO is drained: the number of valid slots, or their values, differs from the first DEPTH slots that were sent.

// File: rtl/srx_pkg.sv
`timescale 1ns/1ps
package srx_pkg;

  // Beats carried per slot for a capture mode.
  function automatic int beats_per_slot(bit ddr);
    return ddr ? 2 : 1;
  endfunction

  function automatic logic [31:0] bin_to_gray(logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray_to_bin(logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // Entries between two binary pointers that carry one wrap bit.
  function automatic logic [31:0] ptr_distance(logic [31:0] ahead, logic [31:0] behind);
    return ahead - behind;
  endfunction

endpackage

// File: rtl/srx_ptr_sync.sv
`timescale 1ns/1ps
module srx_ptr_sync #(
  parameter int  W         = 4,
  parameter bit  ASYNC_CLR = 1'b0
) (
  input  logic         clk,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  generate
    if (ASYNC_CLR) begin : g_async
      always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
          stage1 <= '0;
          q      <= '0;
        end else begin
          stage1 <= d;
          q      <= stage1;
        end
      end
    end else begin : g_sync
      always_ff @(posedge clk) begin
        if (clr) begin
          stage1 <= '0;
          q      <= '0;
        end else begin
          stage1 <= d;
          q      <= stage1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/srx_wr_side.sv
`timescale 1ns/1ps
module srx_wr_side import srx_pkg::*; #(
  parameter int  PIN_WIDTH = 4,
  parameter bit  DDR_MODE  = 1'b1,
  parameter int  DEPTH     = 8,
  localparam int SLOT_W    = PIN_WIDTH * beats_per_slot(DDR_MODE),
  localparam int AW        = $clog2(DEPTH),
  localparam int PW        = AW + 1
) (
  input  logic                          strobe_clk,
  input  logic                          flush_async,
  input  logic [PIN_WIDTH-1:0]          data_in,
  input  logic [PW-1:0]                 rgray_sync,
  output logic                          wclk,
  output logic                          wr_rst,
  output logic [PW-1:0]                 wgray,
  output logic [PW-1:0]                 fill,
  output logic [DEPTH-1:0][SLOT_W-1:0]  mem
);
  logic [SLOT_W-1:0] slot_d;
  logic [1:0]        rst_pipe;
  logic [PW-1:0]     wbin, wbin_nx, rbin_w;
  logic              full, push;

  generate
    if (DDR_MODE) begin : g_ddr
      logic [PIN_WIDTH-1:0] rise_q;
      always_ff @(posedge strobe_clk) rise_q <= data_in;
      assign wclk   = ~strobe_clk;
      assign slot_d = {data_in, rise_q};
    end else begin : g_sdr
      assign wclk   = strobe_clk;
      assign slot_d = data_in;
    end
  endgenerate

  // Reset raised at once, released after two write edges.
  always_ff @(posedge wclk or posedge flush_async) begin
    if (flush_async) rst_pipe <= 2'b11;
    else             rst_pipe <= {rst_pipe[0], 1'b0};
  end
  assign wr_rst = rst_pipe[1];

  assign rbin_w  = PW'(gray_to_bin(32'(rgray_sync)));
  assign fill    = PW'(ptr_distance(32'(wbin), 32'(rbin_w)));
  assign full    = (fill == PW'(DEPTH));
  assign push    = ~wr_rst & ~full;
  assign wbin_nx = push ? wbin + PW'(1) : wbin;

  always_ff @(posedge wclk or posedge flush_async) begin
    if (flush_async) begin
      wbin  <= '0;
      wgray <= '0;
    end else begin
      wbin  <= wbin_nx;
      wgray <= PW'(bin_to_gray(32'(wbin_nx)));
    end
  end

  always_ff @(posedge wclk) begin
    if (push) mem[wbin[AW-1:0]] <= slot_d;
  end
endmodule

// File: rtl/srx_rd_side.sv
`timescale 1ns/1ps
module srx_rd_side import srx_pkg::*; #(
  parameter int  SLOTS  = 2,
  parameter int  SLOT_W = 8,
  parameter int  DEPTH  = 8,
  localparam int AW     = $clog2(DEPTH),
  localparam int PW     = AW + 1
) (
  input  logic                          core_clk,
  input  logic                          flush,
  input  logic [SLOTS-1:0]              rd_en,
  input  logic [PW-1:0]                 wgray_sync,
  input  logic [DEPTH-1:0][SLOT_W-1:0]  mem_rd,
  output logic [SLOTS-1:0]              rd_valid,
  output logic [SLOTS-1:0][SLOT_W-1:0]  rd_word,
  output logic [PW-1:0]                 rgray,
  output logic [PW-1:0]                 avail,
  output logic [PW-1:0]                 rbin,
  output logic [SLOTS-1:0]              pop_vec
);
  logic [PW-1:0]                 wbin_r, taken, rbin_nx;
  logic [SLOTS-1:0][PW-1:0]      idx;
  logic [SLOTS-1:0]              s1_v;
  logic [SLOTS-1:0][SLOT_W-1:0]  s1_d;

  assign wbin_r = PW'(gray_to_bin(32'(wgray_sync)));
  assign avail  = PW'(ptr_distance(32'(wbin_r), 32'(rbin)));

  // Serve enabled slots in ascending order while entries remain.
  always_comb begin
    taken = '0;
    for (int i = 0; i < SLOTS; i++) begin
      pop_vec[i] = 1'b0;
      idx[i]     = rbin + taken;
      if (rd_en[i] && (taken < avail)) begin
        pop_vec[i] = 1'b1;
        taken      = taken + PW'(1);
      end
    end
  end
  assign rbin_nx = rbin + taken;

  always_ff @(posedge core_clk) begin
    if (flush) begin
      rbin     <= '0;
      rgray    <= '0;
      s1_v     <= '0;
      s1_d     <= '0;
      rd_valid <= '0;
      rd_word  <= '0;
    end else begin
      rbin  <= rbin_nx;
      rgray <= PW'(bin_to_gray(32'(rbin_nx)));
      s1_v  <= pop_vec;
      for (int i = 0; i < SLOTS; i++)
        s1_d[i] <= pop_vec[i] ? mem_rd[idx[i][AW-1:0]] : '0;
      rd_valid <= s1_v;
      rd_word  <= s1_d;
    end
  end
endmodule

// File: rtl/strobe_rx_deser.sv
`timescale 1ns/1ps
module strobe_rx_deser import srx_pkg::*; #(
  parameter int  PIN_WIDTH = 4,
  parameter bit  DDR_MODE  = 1'b1,
  parameter int  SLOTS     = 2,
  parameter int  DEPTH     = 8,
  localparam int SLOT_W    = PIN_WIDTH * beats_per_slot(DDR_MODE),
  localparam int WORD_W    = SLOTS * SLOT_W
) (
  input  logic                 strobe_clk,
  input  logic [PIN_WIDTH-1:0] data_in,
  input  logic                 core_clk,
  input  logic                 core_rst,
  input  logic                 iface_locked,
  input  logic                 strobe_ok,
  input  logic [SLOTS-1:0]     rd_en,
  output logic [SLOTS-1:0]     rd_valid,
  output logic [WORD_W-1:0]    rd_data
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic                          flush, flush_q, rd_flush;
  logic                          wclk, wr_rst;
  logic [PW-1:0]                 wgray, wgray_c, rgray, rgray_w;
  logic [PW-1:0]                 wr_fill, avail, rbin;
  logic [SLOTS-1:0]              pop_vec;
  logic [DEPTH-1:0][SLOT_W-1:0]  mem;

  assign flush = core_rst | ~iface_locked | ~strobe_ok;
  always_ff @(posedge core_clk) flush_q <= flush;
  // Read side stays flushed until the write side has been reset.
  assign rd_flush = flush | flush_q;

  srx_wr_side #(.PIN_WIDTH(PIN_WIDTH), .DDR_MODE(DDR_MODE), .DEPTH(DEPTH)) u_wr (
    .strobe_clk (strobe_clk),
    .flush_async(flush_q),
    .data_in    (data_in),
    .rgray_sync (rgray_w),
    .wclk       (wclk),
    .wr_rst     (wr_rst),
    .wgray      (wgray),
    .fill       (wr_fill),
    .mem        (mem)
  );

  srx_ptr_sync #(.W(PW), .ASYNC_CLR(1'b1)) u_rsync (
    .clk(wclk), .clr(flush_q), .d(rgray), .q(rgray_w)
  );

  srx_ptr_sync #(.W(PW), .ASYNC_CLR(1'b0)) u_wsync (
    .clk(core_clk), .clr(rd_flush), .d(wgray), .q(wgray_c)
  );

  srx_rd_side #(.SLOTS(SLOTS), .SLOT_W(SLOT_W), .DEPTH(DEPTH)) u_rd (
    .core_clk  (core_clk),
    .flush     (rd_flush),
    .rd_en     (rd_en),
    .wgray_sync(wgray_c),
    .mem_rd    (mem),
    .rd_valid  (rd_valid),
    .rd_word   (rd_data),
    .rgray     (rgray),
    .avail     (avail),
    .rbin      (rbin),
    .pop_vec   (pop_vec)
  );
endmodule

// File: rtl/srx_chk.sv
`timescale 1ns/1ps
module srx_chk #(
  parameter int SLOTS = 2,
  parameter int DEPTH = 8,
  parameter int PW    = 4
) (
  input logic             core_clk,
  input logic             core_rst,
  input logic             rd_flush,
  input logic [SLOTS-1:0] rd_en,
  input logic [SLOTS-1:0] rd_valid,
  input logic [SLOTS-1:0] pop_vec,
  input logic [PW-1:0]    avail,
  input logic [PW-1:0]    rbin,
  input logic             wclk,
  input logic             wr_rst,
  input logic [PW-1:0]    wr_fill
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  // R4
  valid_req_chk: assert property (@(posedge core_clk) disable iff (core_rst)
    (rd_valid & ~$past(rd_en, 2)) == '0);

  // R7
  flush_clear_chk: assert property (@(posedge core_clk) disable iff (core_rst)
    rd_flush |=> (rd_valid == '0));

  // R5
  empty_hold_chk: assert property (@(posedge core_clk) disable iff (core_rst)
    (!rd_flush && avail == '0) |=> (rbin == $past(rbin)));

  // R6
  pop_bound_chk: assert property (@(posedge core_clk) disable iff (core_rst)
    $countones(pop_vec) <= int'(avail));

  // R9
  avail_bound_chk: assert property (@(posedge core_clk) disable iff (core_rst)
    avail <= DEPTH_P);

  // R9
  no_overflow_chk: assert property (@(posedge wclk) disable iff (wr_rst)
    wr_fill <= DEPTH_P);
endmodule

bind strobe_rx_deser srx_chk #(.SLOTS(SLOTS), .DEPTH(DEPTH), .PW(PW)) u_chk (
  .core_clk(core_clk), .core_rst(core_rst), .rd_flush(rd_flush),
  .rd_en(rd_en), .rd_valid(rd_valid), .pop_vec(pop_vec), .avail(avail),
  .rbin(rbin), .wclk(wclk), .wr_rst(wr_rst), .wr_fill(wr_fill)
);

// File: tb/strobe_rx_deser_bench.sv
`timescale 1ns/1ps
module strobe_rx_deser_bench;
  logic       core_clk = 1'b0;
  logic       strobe_clk = 1'b0;
  logic [3:0] data_in = '0;
  logic       core_rst = 1'b1;
  logic       iface_locked = 1'b1;
  logic       strobe_ok = 1'b1;
  logic [1:0] rd_en = '0;
  logic [1:0] rd_valid;
  logic [15:0] rd_data;
  logic [3:0] rd_en_s = '0;
  logic [3:0] rd_valid_s;
  logic [15:0] rd_data_s;

  int n_chk = 0;
  int n_err = 0;
  int m_n = 0, m_h = 0, m_seed = 0;

  always #10 core_clk = ~core_clk;

  strobe_rx_deser #(.PIN_WIDTH(4), .DDR_MODE(1'b1), .SLOTS(2), .DEPTH(8)) u_strobe_rx_deser (
    .strobe_clk(strobe_clk), .data_in(data_in), .core_clk(core_clk), .core_rst(core_rst),
    .iface_locked(iface_locked), .strobe_ok(strobe_ok), .rd_en(rd_en),
    .rd_valid(rd_valid), .rd_data(rd_data));

  strobe_rx_deser #(.PIN_WIDTH(4), .DDR_MODE(1'b0), .SLOTS(4), .DEPTH(8)) u_strobe_rx_deser_sdr (
    .strobe_clk(strobe_clk), .data_in(data_in), .core_clk(core_clk), .core_rst(core_rst),
    .iface_locked(iface_locked), .strobe_ok(strobe_ok), .rd_en(rd_en_s),
    .rd_valid(rd_valid_s), .rd_data(rd_data_s));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] rise_b(int seed, int j); return 4'(seed + 2*j); endfunction
  function automatic logic [3:0] fall_b(int seed, int j); return 4'(seed + 2*j + 1); endfunction

  // One strobe period: rising beat r, then falling beat f.
  task automatic send_slot(input logic [3:0] r, input logic [3:0] f);
    data_in = r; #4 strobe_clk = 1'b1;
    #4 data_in = f; #4 strobe_clk = 1'b0; #4;
  endtask

  task automatic wait_core(input int n);
    for (int i = 0; i < n; i++) @(negedge core_clk);
  endtask

  // Flush, release, two dropped preamble slots (R10), then n slots.
  task automatic prep(input int n, input int seed);
    @(negedge core_clk); core_rst = 1'b1;
    wait_core(2); core_rst = 1'b0;
    wait_core(2);
    send_slot(4'hA, 4'h5);
    send_slot(4'h5, 4'hA);
    for (int j = 0; j < n; j++) send_slot(rise_b(seed, j), fall_b(seed, j));
    wait_core(6);
    m_n = (n > 8) ? 8 : n; m_h = 0; m_seed = seed;
  endtask

  task automatic pop_ddr(input logic [1:0] en, input string req);
    logic [1:0]  ev;
    logic [15:0] ed;
    int j;
    ev = '0; ed = '0; j = m_h;
    for (int i = 0; i < 2; i++)
      if (en[i] && j < m_n) begin
        ev[i] = 1'b1;
        ed[8*i +: 8] = {fall_b(m_seed, j), rise_b(m_seed, j)};
        j++;
      end
    m_h = j;
    @(negedge core_clk); rd_en = en;
    @(negedge core_clk); rd_en = '0;
    chk(rd_valid == 2'b00, "R4 no valid one cycle after request", 32'(rd_valid), 0);
    @(negedge core_clk);
    chk(rd_valid == ev, {req, " valid"}, 32'(rd_valid), 32'(ev));
    chk(rd_data == ed, {req, " data"}, 32'(rd_data), 32'(ed));
  endtask

  task automatic pop_sdr(input logic [3:0] en, input string req);
    logic [3:0]  ev;
    logic [15:0] ed;
    int j;
    ev = '0; ed = '0; j = m_h;
    for (int i = 0; i < 4; i++)
      if (en[i] && j < m_n) begin
        ev[i] = 1'b1;
        ed[4*i +: 4] = rise_b(m_seed, j);
        j++;
      end
    m_h = j;
    @(negedge core_clk); rd_en_s = en;
    @(negedge core_clk); rd_en_s = '0;
    @(negedge core_clk);
    chk(rd_valid_s == ev, {req, " valid"}, 32'(rd_valid_s), 32'(ev));
    chk(rd_data_s == ed, {req, " data"}, 32'(rd_data_s), 32'(ed));
  endtask

  // Vector table: slots sent, read-enable pattern, data seed.
  localparam int NV = 6;
  localparam int          V_N[NV]    = '{0, 1, 1, 2, 3, 5};
  localparam logic [1:0]  V_EN[NV]   = '{2'b11, 2'b01, 2'b10, 2'b11, 2'b11, 2'b10};
  localparam int          V_SEED[NV] = '{1, 3, 5, 7, 9, 2};

  initial begin
    wait_core(3);
    core_rst = 1'b0;
    wait_core(1);
    // R8 reset state
    chk(rd_valid == 0 && rd_data == 0, "R8 reset state", 32'({rd_valid, rd_data}), 0);
    chk(rd_valid_s == 0 && rd_data_s == 0, "R8 reset state sdr", 32'({rd_valid_s, rd_data_s}), 0);

    // Table walk: R1, R2, R6, R10 ordering and slot layout.
    for (int v = 0; v < NV; v++) begin
      prep(V_N[v], V_SEED[v]);
      pop_ddr(V_EN[v], "R1 R2 R6 R10 table first read");
      pop_ddr(2'b11, "R6 table follow-up read");
    end

    // R5: empty read leaves the pointer in place.
    prep(0, 4);
    pop_ddr(2'b11, "R5 empty read");
    send_slot(rise_b(4, 0), fall_b(4, 0));
    wait_core(6);
    m_n = 1;
    pop_ddr(2'b01, "R5 data after empty read");

    // R9: overflow keeps the oldest DEPTH slots.
    prep(10, 6);
    for (int k = 0; k < 5; k++) pop_ddr(2'b11, "R9 drain after overflow");

    // R7: lock drop flushes; requests while unlocked are ignored.
    prep(3, 8);
    @(negedge core_clk); iface_locked = 1'b0;
    wait_core(2);
    m_n = 0; m_h = 0;
    pop_ddr(2'b11, "R7 request while unlocked");
    iface_locked = 1'b1;
    wait_core(6);
    pop_ddr(2'b11, "R7 nothing after relock");

    // R7: strobe-stable drop flushes as well.
    prep(2, 3);
    @(negedge core_clk); strobe_ok = 1'b0;
    wait_core(2); strobe_ok = 1'b1;
    wait_core(6);
    m_n = 0; m_h = 0;
    pop_ddr(2'b11, "R7 strobe unstable flush");

    // R8: one-cycle reset flushes buffered slots.
    prep(3, 11);
    @(negedge core_clk); core_rst = 1'b1;
    @(negedge core_clk); core_rst = 1'b0;
    wait_core(6);
    m_n = 0; m_h = 0;
    pop_ddr(2'b11, "R8 mid-run reset flush");

    // R3: single data rate, quarter rate.
    prep(5, 6);
    pop_sdr(4'b1111, "R3 R1 sdr full word");
    pop_sdr(4'b0001, "R3 sdr remainder");
    pop_sdr(4'b1111, "R3 sdr empty");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule